// File: doc/BRIEF.md
# Serial Bit-Rate Timing Divider

This block is the timing source of a serial port. From the system clock it makes two strobes. The first is a fine strobe, here called the sample tick. Software can use it as the receiver's oversampling clock. The second is a coarse strobe, the baud tick, which marks each bit boundary. A host sets a divisor `n`, written one byte at a time as a high byte and a low byte. The down-counter divides the clock by `n + 1` and produces the sample tick. A second counter then divides the sample tick by a multiplier. That multiplier comes from three configuration flags: a wide-divisor enable, a fast-rate select and a clocked (synchronous) mode select.

The multiplier is 64 when the narrow divisor is used in asynchronous mode with the fast-rate select off. It is 16 when exactly one of the wide enable and the fast-rate select is set. It is 4 when both are set. In synchronous mode the multiplier is always 4, and the fast-rate select is ignored.

A write to either divisor byte, or to the configuration, restarts both counters in the same edge. Each restart uses the newly written values, so the new rate takes effect at once. A receiver idle flag passes through one register stage, so software can confirm that the line is quiet before it changes the clock.

Top module: `baud_rate_gen`

## Requirements
- R1: While `rst` is high, `baud_tick` and `sample_tick` are 0 and `rx_idle_out` is 1. After reset the divisor is 0 and the mode is narrow, asynchronous, with fast-rate off, so the baud period is 64 cycles with 64 sample ticks.
- R2: `sample_tick` repeats every `n + 1` cycles. When `n > 0` each pulse lasts exactly one cycle.
- R3: In asynchronous narrow mode with `cfg_fast` = 0, the baud period is `64 * (n + 1)` cycles.
- R4: In asynchronous mode the multiplier is 16 for (wide = 0, fast = 1) and for (wide = 1, fast = 0), and it is 4 for (wide = 1, fast = 1).
- R5: With `cfg_sync` = 1 the baud period is `4 * (n + 1)` cycles, whatever the value of `cfg_fast`.
- R6: In narrow mode, `n` is the low byte alone, and the high byte has no effect on either tick.
- R7: In wide mode, `n` is `{high byte, low byte}`.
- R8: A write to either divisor byte or to the configuration restarts the counters with the new values. If the write edge is cycle 0, the first sample tick appears in cycle `n` and the first baud tick in cycle `n + (K - 1) * (n + 1)`, where K is the multiplier. No baud tick appears in the cycle after the write.
- R9: Every baud tick coincides with a sample tick, and each baud period holds exactly K sample ticks.
- R10: `rx_idle_out` equals `rx_idle_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_hi_wr | input | 1 | Write strobe for the divisor high byte |
| div_lo_wr | input | 1 | Write strobe for the divisor low byte |
| div_wdata | input | BYTE_W | Divisor byte written by either strobe |
| cfg_wr | input | 1 | Write strobe for the three mode flags |
| cfg_wide | input | 1 | 1 selects the wide (two-byte) divisor |
| cfg_fast | input | 1 | 1 selects the fast-rate multiplier in asynchronous mode |
| cfg_sync | input | 1 | 1 selects synchronous (clocked) mode |
| rx_idle_in | input | 1 | Receiver idle flag |
| baud_tick | output | 1 | One-cycle strobe at each bit boundary |
| sample_tick | output | 1 | Oversampling strobe, once per divisor period |
| rx_idle_out | output | 1 | Registered copy of `rx_idle_in` |

## Verification
The bench builds the block with its defaults: 8-bit bytes, wide mode enabled, and multipliers of 64, 16 and 4. With these values every multiplier path and the two-byte divisor can be reached. The bench keeps the high byte at 0 or 1 in random trials, which holds the wide-mode periods to a few thousand cycles while still crossing the byte boundary. Directed cases cover the worked 64 × 26 period, a zero divisor, a restart in the middle of a period, and a high byte that is ignored in narrow mode.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;

   typedef struct packed {
      logic wide;
      logic fast;
      logic sync;
   } brg_cfg_t;

   // Sample ticks per bit for a given mode.
   function automatic int unsigned bit_mult(input brg_cfg_t c,
                                            input int unsigned m_slow,
                                            input int unsigned m_mid,
                                            input int unsigned m_fast);
      if (c.sync)
         return m_fast;
      if (c.wide && c.fast)
         return m_fast;
      if (c.wide || c.fast)
         return m_mid;
      return m_slow;
   endfunction

endpackage

// File: rtl/brg_ctrl_regs.sv
`timescale 1ns/1ps
module brg_ctrl_regs
   import brg_pkg::*;
#(
   parameter int unsigned BYTE_W  = 8,
   parameter bit          WIDE_OK = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  hi_wr,
   input  logic                  lo_wr,
   input  logic                  cfg_wr,
   input  logic [BYTE_W-1:0]     wdata,
   input  brg_cfg_t              cfg_in,
   output brg_cfg_t              cfg_q,
   output logic [2*BYTE_W-1:0]   reload_val,
   output logic                  restart
);

   logic [BYTE_W-1:0] hi_q, lo_q;
   logic [BYTE_W-1:0] hi_d, lo_d;
   brg_cfg_t          cfg_raw, cfg_d;

   always_comb begin
      hi_d    = hi_wr  ? wdata  : hi_q;
      lo_d    = lo_wr  ? wdata  : lo_q;
      cfg_raw = cfg_wr ? cfg_in : cfg_q;
   end

   generate
      if (WIDE_OK) begin : g_wide
         assign cfg_d = cfg_raw;
      end else begin : g_narrow
         always_comb begin
            cfg_d      = cfg_raw;
            cfg_d.wide = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q  <= '0;
         lo_q  <= '0;
         cfg_q <= '0;
      end else begin
         hi_q  <= hi_d;
         lo_q  <= lo_d;
         cfg_q <= cfg_d;
      end
   end

   // Reload value built from next-state contents, so a restart uses new data.
   assign reload_val = cfg_d.wide ? {hi_d, lo_d} : {{BYTE_W{1'b0}}, lo_d};
   assign restart    = hi_wr | lo_wr | cfg_wr;

endmodule

// File: rtl/brg_down_counter.sv
`timescale 1ns/1ps
module brg_down_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         restart,
   input  logic [W-1:0] reload_val,
   output logic         tick
);

   logic [W-1:0] cnt_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (restart || at_zero)
         cnt_q <= reload_val;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   assign tick = at_zero & ~rst;

endmodule

// File: rtl/brg_phase_counter.sv
`timescale 1ns/1ps
module brg_phase_counter #(
   parameter int unsigned PW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  logic          tick_in,
   input  logic [PW-1:0] last,
   output logic [PW-1:0] phase_q,
   output logic          baud
);

   logic wrap;

   assign wrap = (phase_q >= last);

   always_ff @(posedge clk) begin
      if (rst || restart)
         phase_q <= '0;
      else if (tick_in)
         phase_q <= wrap ? '0 : phase_q + 1'b1;
   end

   assign baud = tick_in & wrap;

endmodule

// File: rtl/baud_rate_gen.sv
`timescale 1ns/1ps
module baud_rate_gen
   import brg_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter bit          WIDE_OK   = 1'b1,
   parameter int unsigned MULT_SLOW = 64,
   parameter int unsigned MULT_MID  = 16,
   parameter int unsigned MULT_FAST = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              div_hi_wr,
   input  logic              div_lo_wr,
   input  logic [BYTE_W-1:0] div_wdata,
   input  logic              cfg_wr,
   input  logic              cfg_wide,
   input  logic              cfg_fast,
   input  logic              cfg_sync,
   input  logic              rx_idle_in,
   output logic              baud_tick,
   output logic              sample_tick,
   output logic              rx_idle_out
);

   localparam int unsigned DIV_W = 2 * BYTE_W;
   localparam int unsigned PH_W  = (MULT_SLOW > 2) ? $clog2(MULT_SLOW) : 1;

   generate
      if (BYTE_W < 2) begin : g_chk_byte
         $error("baud_rate_gen: BYTE_W must be at least 2");
      end
      if (MULT_FAST < 1 || MULT_MID < MULT_FAST || MULT_SLOW < MULT_MID) begin : g_chk_mult
         $error("baud_rate_gen: multipliers must satisfy 1 <= FAST <= MID <= SLOW");
      end
   endgenerate

   brg_cfg_t          cfg_in, cfg_q;
   logic [DIV_W-1:0]  reload_val;
   logic              restart;
   logic [PH_W-1:0]   mult_last;
   logic [PH_W-1:0]   phase_q;
   logic              rx_idle_q;

   always_comb begin
      cfg_in      = '0;
      cfg_in.wide = cfg_wide;
      cfg_in.fast = cfg_fast;
      cfg_in.sync = cfg_sync;
   end

   brg_ctrl_regs #(
      .BYTE_W (BYTE_W),
      .WIDE_OK(WIDE_OK)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .hi_wr     (div_hi_wr),
      .lo_wr     (div_lo_wr),
      .cfg_wr    (cfg_wr),
      .wdata     (div_wdata),
      .cfg_in    (cfg_in),
      .cfg_q     (cfg_q),
      .reload_val(reload_val),
      .restart   (restart)
   );

   brg_down_counter #(
      .W(DIV_W)
   ) u_div (
      .clk       (clk),
      .rst       (rst),
      .restart   (restart),
      .reload_val(reload_val),
      .tick      (sample_tick)
   );

   always_comb begin
      mult_last = PH_W'(bit_mult(cfg_q, MULT_SLOW, MULT_MID, MULT_FAST) - 1);
   end

   brg_phase_counter #(
      .PW(PH_W)
   ) u_phase (
      .clk    (clk),
      .rst    (rst),
      .restart(restart),
      .tick_in(sample_tick),
      .last   (mult_last),
      .phase_q(phase_q),
      .baud   (baud_tick)
   );

   always_ff @(posedge clk) begin
      if (rst)
         rx_idle_q <= 1'b1;
      else
         rx_idle_q <= rx_idle_in;
   end

   assign rx_idle_out = rx_idle_q;

endmodule

// File: rtl/brg_checker.sv
`timescale 1ns/1ps
module brg_checker #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned PH_W  = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             div_hi_wr,
   input logic             div_lo_wr,
   input logic             cfg_wr,
   input logic             rx_idle_in,
   input logic             rx_idle_out,
   input logic             baud_tick,
   input logic             sample_tick,
   input logic [DIV_W-1:0] reload_val,
   input logic [PH_W-1:0]  phase_q,
   input logic [PH_W-1:0]  mult_last
);

   logic any_wr;
   assign any_wr = div_hi_wr | div_lo_wr | cfg_wr;

   a_r1_quiet_in_reset: assert property (@(posedge clk)
      rst |-> (!baud_tick && !sample_tick));

   a_r9_baud_on_sample: assert property (@(posedge clk) disable iff (rst)
      baud_tick |-> sample_tick);

   a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
      (sample_tick && !any_wr && reload_val != '0) |=> !sample_tick);

   a_r8_restart_no_baud: assert property (@(posedge clk) disable iff (rst)
      any_wr |=> !baud_tick);

   a_r4_phase_in_range: assert property (@(posedge clk) disable iff (rst)
      phase_q <= mult_last);

   a_r10_idle_follow: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (rx_idle_out == $past(rx_idle_in)));

endmodule

bind baud_rate_gen brg_checker #(
   .DIV_W(DIV_W),
   .PH_W (PH_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .div_hi_wr  (div_hi_wr),
   .div_lo_wr  (div_lo_wr),
   .cfg_wr     (cfg_wr),
   .rx_idle_in (rx_idle_in),
   .rx_idle_out(rx_idle_out),
   .baud_tick  (baud_tick),
   .sample_tick(sample_tick),
   .reload_val (reload_val),
   .phase_q    (phase_q),
   .mult_last  (mult_last)
);

// File: tb/tb_baud_rate_gen.sv
`timescale 1ns/1ps
module tb_baud_rate_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       div_hi_wr = 1'b0, div_lo_wr = 1'b0, cfg_wr = 1'b0;
   logic [7:0] div_wdata = '0;
   logic       cfg_wide = 1'b0, cfg_fast = 1'b0, cfg_sync = 1'b0;
   logic       rx_idle_in = 1'b0;
   logic       baud_tick, sample_tick, rx_idle_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   baud_rate_gen dut (
      .clk(clk), .rst(rst),
      .div_hi_wr(div_hi_wr), .div_lo_wr(div_lo_wr), .div_wdata(div_wdata),
      .cfg_wr(cfg_wr), .cfg_wide(cfg_wide), .cfg_fast(cfg_fast), .cfg_sync(cfg_sync),
      .rx_idle_in(rx_idle_in),
      .baud_tick(baud_tick), .sample_tick(sample_tick), .rx_idle_out(rx_idle_out)
   );

   function automatic int exp_mult(bit w, bit f, bit s);
      if (s)      return 4;
      if (w && f) return 4;
      if (w || f) return 16;
      return 64;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Entered at a negedge; the following posedge is the write edge.
   task automatic wr(input int kind, input int data);
      case (kind)
         0: div_lo_wr = 1'b1;
         1: div_hi_wr = 1'b1;
         default: begin
            cfg_wr   = 1'b1;
            cfg_wide = data[0];
            cfg_fast = data[1];
            cfg_sync = data[2];
         end
      endcase
      div_wdata = data[7:0];
      @(negedge clk);
      div_lo_wr = 1'b0;
      div_hi_wr = 1'b0;
      cfg_wr    = 1'b0;
   endtask

   // Sample at successive negedges until a baud tick is seen (inclusive).
   task automatic scan(input int limit, output int steps, output int ticks, output int dbl);
      bit prev = 1'b0;
      steps = 0; ticks = 0; dbl = 0;
      while (1) begin
         if (sample_tick) ticks++;
         if (sample_tick && prev) dbl++;
         prev = sample_tick;
         if (baud_tick) break;
         if (steps >= limit) begin
            steps = -1;
            break;
         end
         @(negedge clk);
         steps++;
      end
   endtask

   task automatic run_case(input string tag, input bit w, input bit f, input bit s,
                           input int hi, input int lo);
      int n, k, st, tk, db, st2, tk2, db2;
      string ptag;
      wr(2, {29'd0, s, f, w});
      wr(0, lo);
      wr(1, hi);
      n = w ? (hi * 256 + lo) : lo;
      k = exp_mult(w, f, s);
      if (tag != "")      ptag = tag;
      else if (s)         ptag = "R5 sync period";
      else if (w)         ptag = "R7 R4 wide period";
      else if (f)         ptag = "R4 fast period";
      else                ptag = "R3 slow period";
      scan(k * (n + 1) + 8, st, tk, db);
      check(st == n + (k - 1) * (n + 1), "R8 first baud offset", st, n + (k - 1) * (n + 1));
      check(tk == k, "R9 sample ticks per bit", tk, k);
      @(negedge clk);
      scan(k * (n + 1) + 8, st2, tk2, db2);
      check(st2 + 1 == k * (n + 1), ptag, st2 + 1, k * (n + 1));
      check(tk2 == k, "R9 sample ticks per period", tk2, k);
      if (n > 0)
         check(db + db2 == 0, "R2 sample tick width", db + db2, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int st, tk, db, mis;
      void'($urandom(32'd2718));

      // R1: quiet outputs and idle flag held during reset
      repeat (3) @(negedge clk);
      check(baud_tick == 1'b0, "R1 baud in reset", baud_tick, 0);
      check(sample_tick == 1'b0, "R1 sample in reset", sample_tick, 0);
      check(rx_idle_out == 1'b1, "R1 idle in reset", rx_idle_out, 1);
      rx_idle_in = 1'b1;
      rst = 1'b0;
      scan(200, st, tk, db);
      check(st >= 0, "R1 baud after reset", st, 63);
      @(negedge clk);
      scan(200, st, tk, db);
      check(st + 1 == 64, "R1 default period", st + 1, 64);
      check(tk == 64, "R1 default ticks", tk, 64);

      // R3: worked example n = 25, multiplier 64
      run_case("R3 slow period n25", 1'b0, 1'b0, 1'b0, 0, 25);
      // R4: the other asynchronous multipliers
      run_case("R4 narrow fast", 1'b0, 1'b1, 1'b0, 0, 9);
      run_case("R7 R4 wide slow 0x100", 1'b1, 1'b0, 1'b0, 1, 0);
      run_case("R7 R4 wide fast 0x102", 1'b1, 1'b1, 1'b0, 1, 2);
      // R5: fast select ignored in synchronous mode
      run_case("R5 sync fast off", 1'b0, 1'b0, 1'b1, 0, 10);
      run_case("R5 sync fast on", 1'b0, 1'b1, 1'b1, 0, 10);
      // R6: high byte ignored in narrow mode
      run_case("R6 high byte ignored", 1'b0, 1'b0, 1'b0, 255, 3);

      // R2: zero divisor gives a sample tick every cycle
      run_case("R2 zero divisor period", 1'b0, 1'b0, 1'b0, 0, 0);
      mis = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (!sample_tick) mis++;
      end
      check(mis == 0, "R2 every-cycle sample", mis, 0);

      // R8: restart in the middle of a long period
      wr(2, 0);
      wr(1, 0);
      wr(0, 200);
      repeat (100) @(negedge clk);
      wr(0, 2);
      scan(400, st, tk, db);
      check(st == 2 + 63 * 3, "R8 mid-period restart", st, 191);

      // R10: idle flag passes through one register
      @(negedge clk);
      rx_idle_in = 1'b0;
      check(rx_idle_out == 1'b1, "R10 idle before edge", rx_idle_out, 1);
      @(negedge clk);
      check(rx_idle_out == 1'b0, "R10 idle low", rx_idle_out, 0);
      rx_idle_in = 1'b1;
      @(negedge clk);
      check(rx_idle_out == 1'b1, "R10 idle high", rx_idle_out, 1);

      // Random trials across modes
      for (int t = 0; t < 6; t++) begin
         bit w, f, s;
         int hi, lo;
         w  = 1'($urandom_range(0, 1));
         f  = 1'($urandom_range(0, 1));
         s  = 1'($urandom_range(0, 1));
         hi = w ? $urandom_range(0, 1) : $urandom_range(0, 255);
         lo = w ? $urandom_range(0, 255) : $urandom_range(0, 63);
         run_case("", w, f, s, hi, lo);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule